// File: doc/BRIEF.md
# Multi-Format Serial Audio Port

This block is the master side of a serial audio link. It makes the bit clock (`sclk`) and the frame sync (`fsync`). In each frame it shifts one stereo pair of capture words out on `sdout`, and it shifts one stereo pair of playback words in from `sdin`. A frame lasts one sample period, which is 64 bit periods. The block has no clock divider of its own. A clock enable, `half_tick`, pulses at twice the bit rate, and each pulse moves the bit clock by one half period. So the bit clock runs at 64 times the sample rate when `half_tick` runs at 128 times it.

A 2-bit select picks one of three frame layouts:
- **Pulse layout** (`00`, with `11` treated the same way): a one-bit sync pulse comes before the frame. The two channel words are followed by a status field.
- **Level layout** (`01`): the sync is high for the left half of the frame and low for the right half. Each word is padded to 32 bit periods.
- **Gated layout** (`10`): the two words are packed into 32 active clocks. The bit clock then stays low for the other 32 bit periods, so the frame length does not change.

The block takes the layout, the mono flag, the capture words and the status bits at a frame boundary only. Inputs that change during a frame have no effect until the next frame.

Top module: `sap_framer`

## Requirements
- R1: While `en` is low, `sclk`, `fsync` and `sdout` are low from the next clock on. Raising `en` starts a new frame with its sync bit period.
- R2: Pulse layout, with bit periods counted from 0 at the first left bit:
  - bits 0..15 carry the left word and bits 16..31 the right word;
  - bit 40 carries `st_int`;
  - bits 48, 49 and 50 carry `st_cen`, `st_pen` and `st_ovr`;
  - every other bit is 0.
- R3: In the pulse layout, `fsync` is high for exactly one bit period, bit period 63, just before bit 0. It is low in every other bit period.
- R4: Level layout: the left word is in bits 0..15 and the right word in bits 32..47, and all other bits are 0. `fsync` is high for bits 0..31 and low for bits 32..63.
- R5: Gated layout: the left word is in bits 0..15 and the right word in bits 16..31. `fsync` is high for bits 0..15 only. `sclk` stays low through bit periods 32..63.
- R6: Each 16-bit word is sent most significant bit first, with the MSB in the first bit period of its slot. The received words follow the same bit order.
- R7: When mono is set, the right slot of `sdout` carries zeros, and both `dac_l` and `dac_r` take the received left word.
- R8: `sdout` and `fsync` change only on a rising `sclk` half step and hold steady across the falling half step. `sdin` is sampled on the falling half step.
- R9: `dac_vld` pulses for one clock, once per frame, just after the last right-channel bit has been sampled. That bit is bit 31 in the pulse and gated layouts and bit 47 in the level layout. `dac_l` and `dac_r` are updated at the same time as the pulse.
- R10: Select value `11` produces the same frame as the pulse layout.
- R11: The layout, mono flag, capture words and status bits are captured at the start of the sync bit period (bit 63). Changes during the frame do not affect the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Port enable |
| fmt | input | 2 | Frame layout select |
| mono | input | 1 | Mono mode |
| st_int | input | 1 | Interrupt status bit |
| st_cen | input | 1 | Capture-enabled status bit |
| st_pen | input | 1 | Playback-enabled status bit |
| st_ovr | input | 1 | Overrange status bit |
| adc_l | input | 16 | Left capture word |
| adc_r | input | 16 | Right capture word |
| half_tick | input | 1 | Half-bit-period clock enable |
| sdin | input | 1 | Serial data in |
| sclk | output | 1 | Bit clock |
| fsync | output | 1 | Frame sync |
| sdout | output | 1 | Serial data out |
| dac_l | output | 16 | Received left word |
| dac_r | output | 16 | Received right word |
| dac_vld | output | 1 | Received pair valid pulse |

## Verification
The hardest situation to reach is a set of input changes made in the middle of a frame. The bench needs to show that these changes stay out of the frame in progress and appear only in the next one.

The stimulus flips the layout, the mono flag, the status bits and both capture words partway through a frame. It then checks every remaining bit period against the values captured at the sync bit. A second directed case drops the enable in the middle of a word, checks that the lines go quiet, and confirms that the port restarts cleanly with a sync bit period.

// File: rtl/sap_framer.sv
module sap_framer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [1:0]   fmt,
  input  logic         mono,
  input  logic         st_int,
  input  logic         st_cen,
  input  logic         st_pen,
  input  logic         st_ovr,
  input  logic [W-1:0] adc_l,
  input  logic [W-1:0] adc_r,
  input  logic         half_tick,
  input  logic         sdin,
  output logic         sclk,
  output logic         fsync,
  output logic         sdout,
  output logic [W-1:0] dac_l,
  output logic [W-1:0] dac_r,
  output logic         dac_vld
);
  localparam int LW   = $clog2(W);
  localparam int SLOT = 4 * W;
  localparam int CW   = $clog2(SLOT);
  localparam logic [CW-1:0] LAST = CW'(SLOT - 1);
  localparam logic [LW-1:0] TOP  = LW'(W - 1);
  localparam logic [LW-1:0] MID  = LW'(W / 2);

  logic          ph;
  logic [CW-1:0] cnt;
  logic [1:0]    fmt_q;
  logic          mono_q;
  logic [W-1:0]  cap_l, cap_r, rx_l, rx_r;
  logic [3:0]    stat_q;
  logic          fsync_q, sdout_q;
  logic          tx_bit, tx_fs;

  wire [1:0]    slot  = cnt[CW-1:LW];
  wire [LW-1:0] lo    = cnt[LW-1:0];
  wire          pulse = (fmt_q[1] == fmt_q[0]);
  wire [1:0]    rslot = (fmt_q == 2'b01) ? 2'd2 : 2'd1;
  wire          gate  = !(fmt_q == 2'b10 && slot[1]);
  wire          last_r = (slot == rslot) && (lo == TOP);

  assign sclk  = ph & gate;
  assign fsync = fsync_q;
  assign sdout = sdout_q;

  always_comb begin
    tx_bit = 1'b0;
    if (slot == 2'd0)
      tx_bit = cap_l[TOP - lo];
    else if (slot == rslot)
      tx_bit = cap_r[TOP - lo];
    else if (pulse && slot == 2'd2 && lo == MID)
      tx_bit = stat_q[3];
    else if (pulse && slot == 2'd3) begin
      case (lo)
        LW'(0):  tx_bit = stat_q[2];
        LW'(1):  tx_bit = stat_q[1];
        LW'(2):  tx_bit = stat_q[0];
        default: tx_bit = 1'b0;
      endcase
    end
  end

  always_comb begin
    case (fmt_q)
      2'b01:   tx_fs = !slot[1];
      2'b10:   tx_fs = (slot == 2'd0);
      default: tx_fs = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= 1'b0; cnt <= LAST; fmt_q <= 2'b00; mono_q <= 1'b0;
      cap_l <= '0; cap_r <= '0; stat_q <= '0; rx_l <= '0; rx_r <= '0;
      fsync_q <= 1'b0; sdout_q <= 1'b0;
      dac_l <= '0; dac_r <= '0; dac_vld <= 1'b0;
    end else if (!en) begin
      ph <= 1'b0; cnt <= LAST;
      fsync_q <= 1'b0; sdout_q <= 1'b0; dac_vld <= 1'b0;
    end else begin
      dac_vld <= 1'b0;
      if (half_tick) begin
        if (!ph) begin
          ph <= 1'b1;
          if (cnt == LAST) begin
            fmt_q   <= fmt;
            mono_q  <= mono;
            cap_l   <= adc_l;
            cap_r   <= mono ? '0 : adc_r;
            stat_q  <= {st_int, st_cen, st_pen, st_ovr};
            sdout_q <= 1'b0;
            fsync_q <= (fmt[1] == fmt[0]);
          end else begin
            sdout_q <= tx_bit;
            fsync_q <= tx_fs;
          end
        end else begin
          ph  <= 1'b0;
          cnt <= cnt + 1'b1;
          if (slot == 2'd0)
            rx_l <= {rx_l[W-2:0], sdin};
          if (slot == rslot)
            rx_r <= {rx_r[W-2:0], sdin};
          if (last_r) begin
            dac_vld <= 1'b1;
            dac_l   <= rx_l;
            dac_r   <= mono_q ? rx_l : {rx_r[W-2:0], sdin};
          end
        end
      end
    end
  end

  // R1
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!sclk && !fsync && !sdout));

  // R8
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && half_tick && ph) |=> ($stable(sdout) && $stable(fsync)));

  // R8
  rx_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dac_vld |-> !sclk);

  // R9
  vld_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dac_vld |=> !dac_vld);

  // R7
  mono_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_vld && mono_q) |-> (dac_l == dac_r));
endmodule

// File: tb/sap_framer_bench.sv
module sap_framer_bench;
  localparam int CLK_P = 10;

  typedef struct packed {
    logic [1:0]  fmt;
    logic        mono;
    logic [3:0]  st;
    logic [15:0] al;
    logic [15:0] ar;
    logic [15:0] sl;
    logic [15:0] sr;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{2'b00, 1'b0, 4'b1010, 16'hA55A, 16'h3C0F, 16'h9001, 16'h0FF1},
    '{2'b00, 1'b0, 4'b0111, 16'hFFFF, 16'h0001, 16'h8000, 16'h7FFE},
    '{2'b01, 1'b0, 4'b1111, 16'h1234, 16'hABCD, 16'hC3A5, 16'h5A3C},
    '{2'b10, 1'b0, 4'b1111, 16'h8001, 16'h7E00, 16'hF000, 16'h000F},
    '{2'b00, 1'b1, 4'b1000, 16'hBEEF, 16'hDEAD, 16'h6B2D, 16'h1111},
    '{2'b01, 1'b1, 4'b0001, 16'h0F0F, 16'hFFFF, 16'h8421, 16'h2222},
    '{2'b10, 1'b1, 4'b0100, 16'hC001, 16'h5555, 16'h1357, 16'h3333},
    '{2'b11, 1'b0, 4'b0101, 16'h7FFE, 16'h8001, 16'hAAAA, 16'h5555}
  };

  logic clk = 0, rst_n = 0, en = 0, mono = 0, half_tick = 0, sdin = 0;
  logic st_int = 0, st_cen = 0, st_pen = 0, st_ovr = 0;
  logic [1:0] fmt = 0;
  logic [15:0] adc_l = 0, adc_r = 0;
  logic sclk, fsync, sdout, dac_vld;
  logic [15:0] dac_l, dac_r;

  int tests = 0, fails = 0, vcnt = 0;

  sap_framer u_sap_framer (
    .clk(clk), .rst_n(rst_n), .en(en), .fmt(fmt), .mono(mono),
    .st_int(st_int), .st_cen(st_cen), .st_pen(st_pen), .st_ovr(st_ovr),
    .adc_l(adc_l), .adc_r(adc_r), .half_tick(half_tick), .sdin(sdin),
    .sclk(sclk), .fsync(fsync), .sdout(sdout),
    .dac_l(dac_l), .dac_r(dac_r), .dac_vld(dac_vld));

  always #(CLK_P/2) clk = ~clk;
  always @(negedge clk) if (dac_vld) vcnt++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic half();
    @(negedge clk) half_tick = 1;
    @(negedge clk) half_tick = 0;
  endtask

  task automatic apply(input vec_t v);
    fmt = v.fmt; mono = v.mono;
    {st_int, st_cen, st_pen, st_ovr} = v.st;
    adc_l = v.al; adc_r = v.ar;
  endtask

  function automatic logic exp_tx(input vec_t v, input int b);
    int s = b / 16, lo = b % 16;
    logic [15:0] r = v.mono ? 16'h0 : v.ar;
    if (b == 63) return 1'b0;
    if (s == 0) return v.al[15-lo];
    if (v.fmt == 2'b01) return (s == 2) ? r[15-lo] : 1'b0;
    if (s == 1) return r[15-lo];
    if (v.fmt == 2'b10) return 1'b0;
    if (s == 2 && lo == 8) return v.st[3];
    if (s == 3 && lo == 0) return v.st[2];
    if (s == 3 && lo == 1) return v.st[1];
    if (s == 3 && lo == 2) return v.st[0];
    return 1'b0;
  endfunction

  function automatic logic exp_fs(input vec_t v, input int b);
    if (v.fmt == 2'b01) return b < 32;
    if (v.fmt == 2'b10) return b < 16;
    return b == 63;
  endfunction

  function automatic logic rx_bit(input vec_t v, input int b);
    int s = b / 16, lo = b % 16;
    int rs = (v.fmt == 2'b01) ? 2 : 1;
    if (b == 63) return 1'b1;
    if (s == 0) return v.sl[15-lo];
    if (s == rs) return v.sr[15-lo];
    return 1'b1;
  endfunction

  task automatic run_frame(input vec_t v, input int poke);
    int v0 = vcnt;
    int lastb = (v.fmt == 2'b01) ? 47 : 31;
    logic hold_o, hold_f;
    apply(v);
    for (int k = 0; k < 64; k++) begin
      int b = (k == 0) ? 63 : k - 1;
      half();
      if (k == poke) begin
        fmt = ~v.fmt; mono = ~v.mono; adc_l = ~v.al; adc_r = ~v.ar;
        {st_int, st_cen, st_pen, st_ovr} = ~v.st;
      end
      chk($sformatf("R5 sclk high b%0d", b), sclk, !(v.fmt == 2'b10 && b >= 32));
      chk($sformatf("R2 R4 R5 R6 R7 R10 R11 sdout b%0d", b), sdout, exp_tx(v, b));
      chk($sformatf("R3 R4 R5 fsync b%0d", b), fsync, exp_fs(v, b));
      hold_o = sdout; hold_f = fsync;
      sdin = rx_bit(v, b);
      half();
      chk($sformatf("R8 sclk low b%0d", b), sclk, 1'b0);
      chk($sformatf("R8 hold b%0d", b), {hold_o, hold_f}, {sdout, fsync});
      if (b == lastb) begin
        chk("R9 vld", dac_vld, 1'b1);
        chk("R9 R6 dac_l", dac_l, v.sl);
        chk("R7 R9 dac_r", dac_r, v.mono ? v.sl : v.sr);
      end
    end
    chk("R9 one pulse per frame", vcnt - v0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset sclk", sclk, 0);
    chk("R1 reset fsync", fsync, 0);
    chk("R1 reset sdout", sdout, 0);
    chk("R9 reset vld", dac_vld, 0);
    rst_n = 1;
    @(negedge clk) en = 1;
    for (int i = 0; i < NV; i++) run_frame(VEC[i], -1);
    // R11: inputs flipped mid-frame, frame unchanged
    run_frame(VEC[0], 20);
    run_frame(VEC[2], 40);
    run_frame(VEC[3], 5);
    // R1: disable mid-word
    apply(VEC[1]);
    half(); half(); half();
    chk("R1 active before drop", sclk, 1'b1);
    @(negedge clk) en = 0;
    @(negedge clk);
    chk("R1 sclk off", sclk, 0);
    chk("R1 fsync off", fsync, 0);
    chk("R1 sdout off", sdout, 0);
    half(); half();
    chk("R1 idle ticks", {sclk, fsync, sdout}, 3'b000);
    @(negedge clk) en = 1;
    run_frame(VEC[1], -1);
    run_frame(VEC[7], -1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule